// File: doc/BRIEF.md
# MII/RMII Data Path Adapter

This block sits between a MAC's 4-bit nibble data path and the external PHY pins. A run-time mode input selects the interface. When the mode input is clear, the adapter uses MII: transmit and receive nibbles, enables, errors, carrier and collision pass straight through without registers. The MAC and PHY then run on their own transmit and receive clocks.

When the mode input is set, the adapter uses RMII. All RMII logic runs on a single 50 MHz reference clock. On transmit, each nibble is sent as two 2-bit pairs, low pair first. A one-cycle take strobe tells the MAC when its current nibble has been accepted. On receive, the adapter locks onto the first `01` pair seen while the combined carrier/valid line is high. It then rebuilds nibbles from successive pairs and produces separate carrier and data-valid outputs, plus a one-cycle nibble strobe. A speed input picks 100 Mb/s or 10 Mb/s. At 10 Mb/s each transmit pair is held for ten reference-clock cycles, and received pairs are sampled once every ten cycles.

Top module: `mii_rmii_adapter`

## Requirements
- R1: With `rmiiMode` = 0, these outputs equal their inputs combinationally: `phyTxData`, `phyTxEn` and `phyTxErr` follow the MAC transmit inputs; `macRxData`, `macRxDv`, `macRxErr`, `macRxCrs` and `macCol` follow the PHY inputs. `macTxTake` and `macRxStrobe` are held at 1.
- R2: With `rmiiMode` = 1, each accepted nibble is sent on `phyTxData[1:0]` as bits [1:0] first, then bits [3:2]. `phyTxEn` equals the accepted enable throughout both pairs. `phyTxData[3:2]`, `phyTxErr` and `macCol` are 0.
- R3: In RMII mode with `speed100` = 1, each pair lasts one cycle. `macTxTake` is high for one cycle in every two. The MAC inputs are accepted at the clock edge that ends a cycle in which `macTxTake` is high.
- R4: In RMII mode with `speed100` = 0, each pair lasts ten cycles and `macTxTake` pulses once every twenty cycles.
- R5: In RMII receive, only `phyRxData[1:0]` is used, and `phyRxDv` carries the combined carrier/valid signal. Pairs are ignored until a `01` pair is sampled with `phyRxDv` high. That pair becomes bits [1:0] of the first nibble, and the next pair becomes bits [3:2].
- R6: In RMII receive with `speed100` = 0, the inputs are sampled once every ten cycles. With `speed100` = 1, they are sampled every cycle.
- R7: Each rebuilt nibble produces exactly one cycle of `macRxStrobe`. During that cycle `macRxDv` is 1 and `macRxData` holds the nibble.
- R8: In RMII mode, `macRxCrs` reports the carrier/valid level sampled on the first pair of the current nibble. When that level is 0 and the second pair's level is 1, the nibble is still delivered with `macRxCrs` = 0 and `macRxDv` = 1.
- R9: A nibble whose two pairs are both sampled with carrier/valid low delivers no strobe. It clears `macRxDv`, and receive returns to searching for `01`.
- R10: `macRxErr` delivered with a nibble is the OR of `phyRxErr` sampled on its two pairs.
- R11: After reset in RMII mode with transmit enable low, `phyTxEn`, `macRxDv` and `macRxStrobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | 50 MHz reference clock, used by RMII logic |
| rstN | input | 1 | Active-low synchronous reset |
| rmiiMode | input | 1 | 1 selects RMII, 0 selects MII |
| speed100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| macTxData | input | 4 | Transmit nibble from the MAC |
| macTxEn | input | 1 | Transmit enable from the MAC |
| macTxErr | input | 1 | Transmit error from the MAC |
| macTxTake | output | 1 | Nibble accepted at the next edge (always 1 in MII mode) |
| macRxData | output | 4 | Received nibble to the MAC |
| macRxDv | output | 1 | Receive data valid to the MAC |
| macRxErr | output | 1 | Receive error to the MAC |
| macRxCrs | output | 1 | Carrier sense to the MAC |
| macCol | output | 1 | Collision to the MAC (0 in RMII mode) |
| macRxStrobe | output | 1 | New received nibble (always 1 in MII mode) |
| phyTxData | output | 4 | Transmit data pins (RMII uses [1:0]) |
| phyTxEn | output | 1 | Transmit enable pin |
| phyTxErr | output | 1 | Transmit error pin (0 in RMII mode) |
| phyRxData | input | 4 | Receive data pins (RMII uses [1:0]) |
| phyRxDv | input | 1 | Data valid (MII) or combined carrier/valid (RMII) |
| phyRxErr | input | 1 | Receive error pin |
| phyCrs | input | 1 | Carrier sense pin (MII only) |
| phyCol | input | 1 | Collision pin (MII only) |

## Verification
The most likely internal faults are a wrong pair-half selector or a miscounted repeat counter on transmit. Either fault changes the level on `phyTxData[1:0]` within one pair period, which is one cycle at 100 Mb/s and ten cycles at 10 Mb/s. A receive state that drifts off nibble alignment produces swapped or shifted nibbles at the very next `macRxStrobe`. A wrong end-of-frame decision shows up as an extra or missing strobe and a `macRxDv` that stays high after the frame has closed. The carrier/valid split is observed at each delivered nibble, so a fault there appears at the first nibble where the line toggles.

// File: rtl/mra_pkg.sv
package mra_pkg;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_LOW  = 2'd1,
    RX_HIGH = 2'd2
  } rxPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // MII mode: hold RMII state idle
    logic txLoad;    // accept MAC nibble at this edge
    logic txHigh;    // current transmit pair is the upper half
    logic rxStart;   // first 01 pair found: capture as low half
    logic rxLowCap;  // capture low half of a nibble
    logic rxEmit;    // high half sampled: deliver nibble
    logic rxEnd;     // carrier gone on both halves: close frame
    logic rxCrsLoad; // update carrier output from line
  } ctlStrobes_t;

endpackage

// File: rtl/mra_ctrl.sv
module mra_ctrl
  import mra_pkg::*;
#(
  parameter int PAIR_W   = 2,
  parameter int SLOW_DIV = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rmiiMode,
  input  logic              speed100,
  input  logic [PAIR_W-1:0] rxPair,
  input  logic              crsDv,
  output ctlStrobes_t       strb,
  output logic              txTake
);

  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PAIR_W-1:0] SYNC_PAIR = PAIR_W'(1);

  logic [CNT_W-1:0] repLast;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic             txHalf;
  logic             txSlotEnd;
  logic             rxSample;
  rxPhase_t         rxPhase;
  rxPhase_t         rxPhaseNext;
  logic             crsLowQ;

  assign repLast   = speed100 ? '0 : CNT_W'(SLOW_DIV - 1);
  assign txSlotEnd = (txCnt >= repLast);
  assign rxSample  = rmiiMode && (rxCnt >= repLast);

  // transmit pacing: pair repeat counter and half selector
  always_ff @(posedge clk) begin
    if (!rstN || !rmiiMode) begin
      txCnt  <= '0;
      txHalf <= 1'b1;
    end else if (txSlotEnd) begin
      txCnt  <= '0;
      txHalf <= ~txHalf;
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  assign txTake = rmiiMode ? (txSlotEnd && txHalf) : 1'b1;

  // receive sampling cadence
  always_ff @(posedge clk) begin
    if (!rstN || !rmiiMode) begin
      rxCnt <= '0;
    end else if (rxSample) begin
      rxCnt <= '0;
    end else begin
      rxCnt <= rxCnt + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.clear     = !rmiiMode;
    strb.txLoad    = rmiiMode && txSlotEnd && txHalf;
    strb.txHigh    = txHalf;
    rxPhaseNext    = rxPhase;
    if (rxSample) begin
      unique case (rxPhase)
        RX_HUNT: begin
          strb.rxCrsLoad = 1'b1;
          if (crsDv && rxPair == SYNC_PAIR) begin
            strb.rxStart = 1'b1;
            rxPhaseNext  = RX_HIGH;
          end
        end
        RX_LOW: begin
          strb.rxLowCap  = 1'b1;
          strb.rxCrsLoad = 1'b1;
          rxPhaseNext    = RX_HIGH;
        end
        RX_HIGH: begin
          if (!crsLowQ && !crsDv) begin
            strb.rxEnd  = 1'b1;
            rxPhaseNext = RX_HUNT;
          end else begin
            strb.rxEmit = 1'b1;
            rxPhaseNext = RX_LOW;
          end
        end
        default: rxPhaseNext = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rmiiMode) begin
      rxPhase <= RX_HUNT;
      crsLowQ <= 1'b0;
    end else begin
      rxPhase <= rxPhaseNext;
      if (strb.rxStart) begin
        crsLowQ <= 1'b1;
      end else if (strb.rxLowCap) begin
        crsLowQ <= crsDv;
      end
    end
  end

endmodule

// File: rtl/mra_datapath.sv
module mra_datapath
  import mra_pkg::*;
#(
  parameter int PAIR_W = 2,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [NIB_W-1:0]  macTxData,
  input  logic              macTxEn,
  input  logic [PAIR_W-1:0] rxPair,
  input  logic              rxErrIn,
  input  logic              crsDv,
  output logic [PAIR_W-1:0] txPair,
  output logic              txEnQ,
  output logic [NIB_W-1:0]  rxNib,
  output logic              rxDvQ,
  output logic              rxStrobeQ,
  output logic              rxErrQ,
  output logic              rxCrsQ
);

  logic [NIB_W-1:0]  txNib;
  logic [PAIR_W-1:0] lowPair;
  logic              errLow;

  // transmit nibble holding register
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      txNib <= '0;
      txEnQ <= 1'b0;
    end else if (strb.txLoad) begin
      txNib <= macTxData;
      txEnQ <= macTxEn;
    end
  end

  assign txPair = strb.txHigh ? txNib[PAIR_W +: PAIR_W] : txNib[0 +: PAIR_W];

  // receive nibble assembly
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      lowPair   <= '0;
      errLow    <= 1'b0;
      rxNib     <= '0;
      rxDvQ     <= 1'b0;
      rxStrobeQ <= 1'b0;
      rxErrQ    <= 1'b0;
      rxCrsQ    <= 1'b0;
    end else begin
      rxStrobeQ <= strb.rxEmit;
      if (strb.rxStart || strb.rxLowCap) begin
        lowPair <= rxPair;
        errLow  <= rxErrIn;
      end
      if (strb.rxEmit) begin
        rxNib  <= {rxPair, lowPair};
        rxErrQ <= errLow | rxErrIn;
        rxDvQ  <= 1'b1;
      end else if (strb.rxEnd) begin
        rxErrQ <= 1'b0;
        rxDvQ  <= 1'b0;
      end
      if (strb.rxCrsLoad) begin
        rxCrsQ <= crsDv;
      end
    end
  end

endmodule

// File: rtl/mii_rmii_adapter.sv
module mii_rmii_adapter
  import mra_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int SLOW_DIV = 10
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             rmiiMode,
  input  logic             speed100,
  input  logic [NIB_W-1:0] macTxData,
  input  logic             macTxEn,
  input  logic             macTxErr,
  output logic             macTxTake,
  output logic [NIB_W-1:0] macRxData,
  output logic             macRxDv,
  output logic             macRxErr,
  output logic             macRxCrs,
  output logic             macCol,
  output logic             macRxStrobe,
  output logic [NIB_W-1:0] phyTxData,
  output logic             phyTxEn,
  output logic             phyTxErr,
  input  logic [NIB_W-1:0] phyRxData,
  input  logic             phyRxDv,
  input  logic             phyRxErr,
  input  logic             phyCrs,
  input  logic             phyCol
);

  localparam int PAIR_W = NIB_W / 2;
  localparam int PAD_W  = NIB_W - PAIR_W;

  ctlStrobes_t       strb;
  logic [PAIR_W-1:0] txPair;
  logic              txEnQ;
  logic [NIB_W-1:0]  rxNib;
  logic              rxDvQ;
  logic              rxStrobeQ;
  logic              rxErrQ;
  logic              rxCrsQ;
  logic              rmiiTake;

  mra_ctrl #(
    .PAIR_W  (PAIR_W),
    .SLOW_DIV(SLOW_DIV)
  ) u_ctrl (
    .clk     (refClk),
    .rstN    (rstN),
    .rmiiMode(rmiiMode),
    .speed100(speed100),
    .rxPair  (phyRxData[PAIR_W-1:0]),
    .crsDv   (phyRxDv),
    .strb    (strb),
    .txTake  (rmiiTake)
  );

  mra_datapath #(
    .PAIR_W(PAIR_W),
    .NIB_W (NIB_W)
  ) u_datapath (
    .clk      (refClk),
    .rstN     (rstN),
    .strb     (strb),
    .macTxData(macTxData),
    .macTxEn  (macTxEn),
    .rxPair   (phyRxData[PAIR_W-1:0]),
    .rxErrIn  (phyRxErr),
    .crsDv    (phyRxDv),
    .txPair   (txPair),
    .txEnQ    (txEnQ),
    .rxNib    (rxNib),
    .rxDvQ    (rxDvQ),
    .rxStrobeQ(rxStrobeQ),
    .rxErrQ   (rxErrQ),
    .rxCrsQ   (rxCrsQ)
  );

  // pin multiplexing between the two interface modes
  always_comb begin
    if (rmiiMode) begin
      phyTxData   = {{PAD_W{1'b0}}, txPair};
      phyTxEn     = txEnQ;
      phyTxErr    = 1'b0;
      macTxTake   = rmiiTake;
      macRxData   = rxNib;
      macRxDv     = rxDvQ;
      macRxErr    = rxErrQ;
      macRxCrs    = rxCrsQ;
      macCol      = 1'b0;
      macRxStrobe = rxStrobeQ;
    end else begin
      phyTxData   = macTxData;
      phyTxEn     = macTxEn;
      phyTxErr    = macTxErr;
      macTxTake   = 1'b1;
      macRxData   = phyRxData;
      macRxDv     = phyRxDv;
      macRxErr    = phyRxErr;
      macRxCrs    = phyCrs;
      macCol      = phyCol;
      macRxStrobe = 1'b1;
    end
  end

endmodule

// File: rtl/mra_checker.sv
module mra_checker (
  input logic refClk,
  input logic rstN,
  input logic rmiiMode,
  input logic speed100,
  input logic macTxTake,
  input logic macRxStrobe,
  input logic macRxDv,
  input logic macRxCrs
);

  // R3: at 100 Mb/s a take pulse is never followed by another one
  assert_take_gap_R3: assert property (@(posedge refClk) disable iff (!rstN)
    (rmiiMode && speed100 && macTxTake) |=> (!rmiiMode || !speed100 || !macTxTake));

  // R7: nibble strobe lasts a single cycle
  assert_strobe_pulse_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (rmiiMode && macRxStrobe) |=> (!rmiiMode || !macRxStrobe));

  // R7: data valid is high whenever a nibble is delivered
  assert_dv_on_strobe_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (rmiiMode && macRxStrobe) |-> macRxDv);

  // R9: a frame closes only with carrier already reported low
  assert_end_no_crs_R9: assert property (@(posedge refClk) disable iff (!rstN)
    (rmiiMode && $past(rmiiMode) && $fell(macRxDv)) |-> !macRxCrs);

  // R1: MII mode keeps both handshake strobes high
  assert_mii_strobes_R1: assert property (@(posedge refClk) disable iff (!rstN)
    !rmiiMode |-> (macTxTake && macRxStrobe));

endmodule

bind mii_rmii_adapter mra_checker u_mraChecker (
  .refClk     (refClk),
  .rstN       (rstN),
  .rmiiMode   (rmiiMode),
  .speed100   (speed100),
  .macTxTake  (macTxTake),
  .macRxStrobe(macRxStrobe),
  .macRxDv    (macRxDv),
  .macRxCrs   (macRxCrs)
);

// File: tb/test_mii_rmii_adapter.sv
module test_mii_rmii_adapter;

  localparam int CLK_PERIOD = 20;

  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       rmiiMode = 1'b1;
  logic       speed100 = 1'b1;
  logic [3:0] macTxData = '0;
  logic       macTxEn = 1'b0;
  logic       macTxErr = 1'b0;
  logic       macTxTake;
  logic [3:0] macRxData;
  logic       macRxDv;
  logic       macRxErr;
  logic       macRxCrs;
  logic       macCol;
  logic       macRxStrobe;
  logic [3:0] phyTxData;
  logic       phyTxEn;
  logic       phyTxErr;
  logic [3:0] phyRxData = '0;
  logic       phyRxDv = 1'b0;
  logic       phyRxErr = 1'b0;
  logic       phyCrs = 1'b0;
  logic       phyCol = 1'b0;

  int total = 0;
  int bad = 0;
  int rep = 1;

  typedef struct {logic [3:0] d; logic en;} txItem_t;
  typedef struct {logic [3:0] d; logic crs; logic err;} rxItem_t;
  txItem_t txQ[$];
  rxItem_t rxQ[$];

  always #(CLK_PERIOD / 2) refClk = ~refClk;

  mii_rmii_adapter i_mii_rmii_adapter (
    .refClk(refClk), .rstN(rstN), .rmiiMode(rmiiMode), .speed100(speed100),
    .macTxData(macTxData), .macTxEn(macTxEn), .macTxErr(macTxErr),
    .macTxTake(macTxTake), .macRxData(macRxData), .macRxDv(macRxDv),
    .macRxErr(macRxErr), .macRxCrs(macRxCrs), .macCol(macCol),
    .macRxStrobe(macRxStrobe), .phyTxData(phyTxData), .phyTxEn(phyTxEn),
    .phyTxErr(phyTxErr), .phyRxData(phyRxData), .phyRxDv(phyRxDv),
    .phyRxErr(phyRxErr), .phyCrs(phyCrs), .phyCol(phyCol)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
    #1;
  endtask

  // transmit driver: push expectation, wait for acceptance
  task automatic txSend(input logic [3:0] d, input logic en);
    txItem_t it;
    macTxData = d;
    macTxEn   = en;
    it.d = d;
    it.en = en;
    txQ.push_back(it);
    do @(negedge refClk); while (!macTxTake);
    @(posedge refClk);
    #1;
  endtask

  task automatic rxPair(input logic [1:0] p, input logic crs);
    phyRxData = {2'b11, p};
    phyRxDv   = crs;
    phyRxErr  = 1'b0;
    repeat (rep) @(negedge refClk);
    #1;
  endtask

  task automatic rxNibble(input logic [3:0] n, input logic cL, input logic cH,
                          input logic eL, input logic eH);
    rxItem_t it;
    if (cL || cH) begin
      it.d = n;
      it.crs = cL;
      it.err = eL | eH;
      rxQ.push_back(it);
    end
    phyRxData = {2'b11, n[1:0]};
    phyRxDv   = cL;
    phyRxErr  = eL;
    repeat (rep) @(negedge refClk);
    #1;
    phyRxData = {2'b11, n[3:2]};
    phyRxDv   = cH;
    phyRxErr  = eH;
    repeat (rep) @(negedge refClk);
    #1;
  endtask

  // transmit monitor
  logic [3:0] mD = '0;
  logic       mEn = 1'b0;
  int slotLen = 1;
  int slotLeft = 0;
  always @(negedge refClk) begin
    if (!rstN || !rmiiMode) begin
      slotLeft = 0;
      mD = '0;
      mEn = 1'b0;
    end else begin
      if (slotLeft > 0) begin
        int idx;
        logic [1:0] expP;
        idx = 2 * slotLen - slotLeft;
        expP = (idx < slotLen) ? mD[1:0] : mD[3:2];
        check(phyTxData === {2'b00, expP} && phyTxEn === mEn,
              (slotLen == 1) ? "R2 R3" : "R2 R4", "tx pair/en",
              {phyTxEn, phyTxData}, {mEn, 2'b00, expP});
        slotLeft--;
      end
      if (macTxTake) begin
        if (txQ.size() > 0) begin
          txItem_t it;
          it = txQ.pop_front();
          mD = it.d;
          mEn = it.en;
        end
        slotLen = rep;
        slotLeft = 2 * rep;
      end
    end
  end

  // receive monitor
  always @(negedge refClk) begin
    if (rstN && rmiiMode && macRxStrobe) begin
      if (rxQ.size() == 0) begin
        check(1'b0, "R9", "unexpected nibble", macRxData, 0);
      end else begin
        rxItem_t it;
        it = rxQ.pop_front();
        check(macRxData === it.d, (rep == 1) ? "R5" : "R5 R6", "rx nibble", macRxData, it.d);
        check(macRxDv === 1'b1, "R7", "dv at strobe", macRxDv, 1);
        check(macRxCrs === it.crs, "R8", "carrier", macRxCrs, it.crs);
        check(macRxErr === it.err, "R10", "rx error", macRxErr, it.err);
      end
    end
  end

  task automatic runTx();
    txSend(4'hA, 1'b1);
    txSend(4'h5, 1'b1);
    txSend(4'h3, 1'b1);
    txSend(4'hC, 1'b1);
    txSend(4'h9, 1'b1);
    txSend(4'h0, 1'b0);
    repeat (4 * rep) @(negedge refClk);
    #1;
  endtask

  task automatic runRx();
    rxPair(2'b01, 1'b0);
    rxPair(2'b00, 1'b1);
    rxPair(2'b10, 1'b1);
    rxNibble(4'h5, 1, 1, 0, 0);
    rxNibble(4'h5, 1, 1, 0, 0);
    rxNibble(4'hD, 1, 1, 0, 0);
    rxNibble(4'h3, 1, 1, 0, 0);
    rxNibble(4'hA, 1, 1, 0, 1);
    rxNibble(4'hC, 1, 1, 1, 0);
    rxNibble(4'h6, 0, 1, 0, 0);
    rxNibble(4'h9, 0, 1, 0, 0);
    rxNibble(4'h0, 0, 0, 0, 0);
    rxPair(2'b01, 1'b0);
    rxPair(2'b00, 1'b0);
    repeat (2 * rep) @(negedge refClk);
    check(rxQ.size() == 0, "R9", "nibbles missing", rxQ.size(), 0);
    check(macRxDv === 1'b0, "R9", "dv after end", macRxDv, 0);
    #1;
  endtask

  task automatic countTakes(input int cycles, input int exp, input string req);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge refClk);
      if (macTxTake) n++;
    end
    check(n == exp, req, "take count", n, exp);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state (R11)
    doReset();
    @(negedge refClk);
    check(phyTxEn === 1'b0, "R11", "phyTxEn after reset", phyTxEn, 0);
    check(macRxDv === 1'b0, "R11", "macRxDv after reset", macRxDv, 0);
    check(macRxStrobe === 1'b0, "R11", "strobe after reset", macRxStrobe, 0);
    #1;

    // RMII 100 Mb/s
    rep = 1;
    countTakes(20, 10, "R3");
    runTx();
    macTxErr = 1'b1;
    phyCol = 1'b1;
    #1;
    check(phyTxErr === 1'b0 && macCol === 1'b0, "R2", "err/col in RMII",
          {phyTxErr, macCol}, 0);
    macTxErr = 1'b0;
    phyCol = 1'b0;
    runRx();

    // RMII 10 Mb/s
    speed100 = 1'b0;
    rep = 10;
    doReset();
    countTakes(60, 3, "R4");
    runTx();
    runRx();

    // MII pass-through (R1)
    rmiiMode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] v;
      v = 4'(k * 5 + 3);
      macTxData = v;
      macTxEn = k[0];
      macTxErr = k[1];
      phyRxData = ~v;
      phyRxDv = ~k[0];
      phyRxErr = k[0];
      phyCrs = k[1];
      phyCol = ~k[1];
      @(negedge refClk);
      check(phyTxData === v && phyTxEn === k[0] && phyTxErr === k[1], "R1",
            "mii tx", {phyTxErr, phyTxEn, phyTxData}, {k[1], k[0], v});
      check(macRxData === ~v && macRxDv === ~k[0] && macRxErr === k[0], "R1",
            "mii rx", {macRxErr, macRxDv, macRxData}, {k[0], ~k[0], ~v});
      check(macRxCrs === k[1] && macCol === ~k[1], "R1", "mii crs/col",
            {macRxCrs, macCol}, {k[1], ~k[1]});
      check(macTxTake === 1'b1 && macRxStrobe === 1'b1, "R1", "mii strobes",
            {macTxTake, macRxStrobe}, 3);
      #1;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule